// File: doc/BRIEF.md
# Software-Triggered Reset Sequencer

This block lets software start either of two reset flavours by writing a small control register. The full flavour drives an internal reset and the reset output pin together. It applies the wake configuration, and the PLL configuration when enabled, at the moment reset begins. It then holds reset until a PLL lock input is seen and a programmable number of cycles has passed. After that it samples the wake and boot configuration pins and releases both resets after a fixed four-cycle tail. The lighter flavour pulses only the reset output pin for a fixed number of clocks, so that external devices are reset while the internal logic keeps running.

A status register keeps one sticky flag per reset flavour, together with the configuration sampled by the last full reset. Software clears the flags by writing 1 to them. The two trigger bits clear themselves: the full-reset bit when its sequence ends, and the pin-only bit when its pulse ends.

Top module: `swrst_seq`

## Requirements
- R1: A bus write to address 0 with data bit 0 set, while no sequence is active, raises `sys_rst_o` and `rst_out_o` in the next cycle. A full-reset write while a sequence is active is ignored. `sys_rst_o` is never high without `rst_out_o`.
- R2: At the edge that starts a full reset, `wake_cfg_o` takes `wake_pin`. `pll_cfg_o` takes `pll_cfg_pins` at that edge only if `cfg_en` is high, and otherwise keeps its previous value. Both are read back at address 2: bit 0 is the wake value and bits 2:1 are the PLL value.
- R3: A full reset stays in its wait phase for as long as `pll_lock` is low. Let L be the first edge at which `pll_lock` is seen high. At edge L+POST_LOCK the wake pin is captured, and the boot pins are captured only if `cfg_en` is high; otherwise the previous boot value is kept.
- R4: Both resets fall at edge L+POST_LOCK+4. At that same edge the captured values are written into the status register: bit 2 holds the wake value and bits 4:3 hold the boot value.
- R5: At the end of a full reset, status bit 0 (full-reset flag) is set and status bit 1 (pin-only flag) is cleared.
- R6: A bus write to address 0 with data bit 1 set, while idle, raises `rst_out_o` for exactly EXT_LEN cycles. During this pulse `sys_rst_o` stays low and status bits 4:2 are not changed.
- R7: Control readback at address 0 shows bit 1 high while the pin-only pulse is active and low again once it ends. Bit 0 shows that a full reset is in progress.
- R8: A pin-only reset sets status bit 1 and leaves status bit 0 unchanged. Bit 1 stays set after the pulse ends.
- R9: A bus write to address 1 clears each of status bits 1:0 whose data bit is 1. Bits written as 0 keep their value.
- R10: A pin-only write while any sequence is active is ignored. The active pulse still ends at its original time, and no flag is set.
- R11: If one control write sets both bit 0 and bit 1, the full reset starts and the pin-only request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 status) |
| wr_data | input | 2 | Write data (trigger bits or clear mask) |
| rd_addr | input | ADDR_W | Read address (0 control, 1 status, 2 applied config) |
| rd_data | output | 5 | Read data, combinational |
| pll_lock | input | 1 | PLL lock indication |
| cfg_en | input | 1 | Reset-configuration enable |
| wake_pin | input | 1 | Wake configuration pin |
| boot_pins | input | 2 | Boot configuration pins |
| pll_cfg_pins | input | 2 | PLL configuration pins |
| sys_rst_o | output | 1 | Internal reset, active high |
| rst_out_o | output | 1 | Reset output pin, active high |
| wake_cfg_o | output | 1 | Applied wake configuration |
| pll_cfg_o | output | 2 | Applied PLL configuration |

## Verification
The hardest case is proving that the capture happens at exactly edge L+POST_LOCK and not one cycle early or late. Seen from the ports, a misplaced sample edge looks the same as a correct one unless the pins change around it. The bench therefore holds decoy values on the wake and boot pins for the whole post-lock count. It switches to the target values for the single cycle before the sample edge and restores the decoys right after it. It also shifts the wake pin away from its applied value, so that the value applied at the start and the value captured later can be told apart.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT_LOCK,
    SQ_HOLD,
    SQ_TAIL,
    SQ_PIN_PULSE
  } seq_state_t;

  localparam int TAIL_CYC = 4;
  localparam int STAT_W   = 5;

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CFG  = 2;

  localparam int CTRL_SYS = 0;
  localparam int CTRL_EXT = 1;

  localparam int ST_SYS   = 0;
  localparam int ST_EXT   = 1;
  localparam int ST_WAKE  = 2;
  localparam int ST_BOOT  = 3;

  function automatic logic span_done(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) == len;
  endfunction

  function automatic logic [STAT_W-1:0] stat_on_sys_done(input logic wake,
                                                         input logic [1:0] boot);
    return {boot, wake, 1'b0, 1'b1};
  endfunction

  function automatic logic [STAT_W-1:0] stat_after_bus(input logic [STAT_W-1:0] cur,
                                                       input logic clr,
                                                       input logic [1:0] mask,
                                                       input logic set_ext);
    logic [STAT_W-1:0] n;
    n = cur;
    if (clr) n[1:0] = cur[1:0] & ~mask;
    if (set_ext) n[ST_EXT] = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/swrst_fsm.sv
module swrst_fsm
  import swrst_pkg::*;
#(
  parameter int POST_LOCK = 32,
  parameter int EXT_LEN   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_req,
  input  logic       ext_req,
  input  logic       pll_lock,
  output seq_state_t state_o,
  output logic       sys_start,
  output logic       ext_start,
  output logic       sample_evt,
  output logic       sys_done,
  output logic       ext_done,
  output logic       sys_rst_o,
  output logic       rst_out_o
);

  localparam int SPAN_A   = (POST_LOCK > EXT_LEN) ? POST_LOCK : EXT_LEN;
  localparam int SPAN_MAX = (SPAN_A > TAIL_CYC) ? SPAN_A : TAIL_CYC;
  localparam int CNT_W    = $clog2(SPAN_MAX + 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             lock_go;

  assign sys_start  = sys_req && (st_q == SQ_IDLE);
  assign ext_start  = ext_req && !sys_req && (st_q == SQ_IDLE);
  assign lock_go    = (st_q == SQ_WAIT_LOCK) && pll_lock;
  assign sample_evt = (st_q == SQ_HOLD) && span_done(32'(cnt_q), POST_LOCK);
  assign sys_done   = (st_q == SQ_TAIL) && span_done(32'(cnt_q), TAIL_CYC);
  assign ext_done   = (st_q == SQ_PIN_PULSE) && span_done(32'(cnt_q), EXT_LEN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (sys_req)      st_d = SQ_WAIT_LOCK;
        else if (ext_req) st_d = SQ_PIN_PULSE;
      end
      SQ_WAIT_LOCK: if (lock_go)    st_d = SQ_HOLD;
      SQ_HOLD:      if (sample_evt) st_d = SQ_TAIL;
      SQ_TAIL:      if (sys_done)   st_d = SQ_IDLE;
      SQ_PIN_PULSE: if (ext_done)   st_d = SQ_IDLE;
      default:                      st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)
        cnt_q <= '0;
      else if (st_q inside {SQ_HOLD, SQ_TAIL, SQ_PIN_PULSE})
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o   = st_q;
  assign sys_rst_o = st_q inside {SQ_WAIT_LOCK, SQ_HOLD, SQ_TAIL};
  assign rst_out_o = (st_q != SQ_IDLE);

  assert_sys_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_start |=> (sys_rst_o && rst_out_o));

  assert_int_implies_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> rst_out_o);

  assert_wait_for_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_WAIT_LOCK) && !pll_lock) |=> (st_q == SQ_WAIT_LOCK));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_done |=> (!rst_out_o && !sys_rst_o));

  assert_pin_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> (rst_out_o && !sys_rst_o));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && (st_q == SQ_PIN_PULSE) && !ext_done) |=> (st_q == SQ_PIN_PULSE));

  assert_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req && ext_req && (st_q == SQ_IDLE)) |=> sys_rst_o);

endmodule

// File: rtl/swrst_cfg.sv
module swrst_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_start,
  input  logic       sample_evt,
  input  logic       cfg_en,
  input  logic       wake_pin,
  input  logic [1:0] boot_pins,
  input  logic [1:0] pll_cfg_pins,
  output logic       wake_app,
  output logic [1:0] pll_app,
  output logic       samp_wake,
  output logic [1:0] samp_boot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_app  <= 1'b0;
      pll_app   <= 2'b00;
      samp_wake <= 1'b0;
      samp_boot <= 2'b00;
    end else begin
      if (sys_start) begin
        wake_app <= wake_pin;
        if (cfg_en) pll_app <= pll_cfg_pins;
      end
      if (sample_evt) begin
        samp_wake <= wake_pin;
        if (cfg_en) samp_boot <= boot_pins;
      end
    end
  end

  assert_wake_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_start |=> (wake_app == $past(wake_pin)));

  assert_pll_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_start && !cfg_en) |=> $stable(pll_app));

  assert_boot_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !cfg_en) |=> $stable(samp_boot));

endmodule

// File: rtl/swrst_status.sv
module swrst_status
  import swrst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_done,
  input  logic              ext_start,
  input  logic              clr_wr,
  input  logic [1:0]        clr_mask,
  input  logic              samp_wake,
  input  logic [1:0]        samp_boot,
  output logic [STAT_W-1:0] stat_o
);

  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else if (sys_done)
      stat_q <= stat_on_sys_done(samp_wake, samp_boot);
    else
      stat_q <= stat_after_bus(stat_q, clr_wr, clr_mask, ext_start);
  end

  assign stat_o = stat_q;

  assert_sys_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_done |=> (stat_q[ST_SYS] && !stat_q[ST_EXT]));

  assert_fields_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> $stable(stat_q[STAT_W-1:ST_WAKE]));

  assert_ext_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> stat_q[ST_EXT]);

  assert_ext_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_start && !sys_done && !(clr_wr && clr_mask[ST_EXT])) |=> $stable(stat_q[ST_EXT]));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[ST_SYS] && !sys_done) |=> !stat_q[ST_SYS]);

endmodule

// File: rtl/swrst_seq.sv
module swrst_seq
  import swrst_pkg::*;
#(
  parameter int POST_LOCK = 32,
  parameter int EXT_LEN   = 16,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_data,
  input  logic              pll_lock,
  input  logic              cfg_en,
  input  logic              wake_pin,
  input  logic [1:0]        boot_pins,
  input  logic [1:0]        pll_cfg_pins,
  output logic              sys_rst_o,
  output logic              rst_out_o,
  output logic              wake_cfg_o,
  output logic [1:0]        pll_cfg_o
);

  seq_state_t        state;
  logic              ctrl_wr, stat_wr, sys_req, ext_req;
  logic              sys_start, ext_start, sample_evt, sys_done, ext_done;
  logic              samp_wake;
  logic [1:0]        samp_boot;
  logic [STAT_W-1:0] stat;
  logic              ext_bit, sys_busy;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign stat_wr = wr_en && (wr_addr == ADDR_W'(REG_STAT));
  assign sys_req = ctrl_wr && wr_data[CTRL_SYS];
  assign ext_req = ctrl_wr && wr_data[CTRL_EXT];

  swrst_fsm #(
    .POST_LOCK(POST_LOCK),
    .EXT_LEN  (EXT_LEN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_req   (sys_req),
    .ext_req   (ext_req),
    .pll_lock  (pll_lock),
    .state_o   (state),
    .sys_start (sys_start),
    .ext_start (ext_start),
    .sample_evt(sample_evt),
    .sys_done  (sys_done),
    .ext_done  (ext_done),
    .sys_rst_o (sys_rst_o),
    .rst_out_o (rst_out_o)
  );

  swrst_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_start   (sys_start),
    .sample_evt  (sample_evt),
    .cfg_en      (cfg_en),
    .wake_pin    (wake_pin),
    .boot_pins   (boot_pins),
    .pll_cfg_pins(pll_cfg_pins),
    .wake_app    (wake_cfg_o),
    .pll_app     (pll_cfg_o),
    .samp_wake   (samp_wake),
    .samp_boot   (samp_boot)
  );

  swrst_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_done (sys_done),
    .ext_start(ext_start),
    .clr_wr   (stat_wr),
    .clr_mask (wr_data),
    .samp_wake(samp_wake),
    .samp_boot(samp_boot),
    .stat_o   (stat)
  );

  assign ext_bit  = (state == SQ_PIN_PULSE);
  assign sys_busy = state inside {SQ_WAIT_LOCK, SQ_HOLD, SQ_TAIL};

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_CTRL)) begin
      rd_data[CTRL_SYS] = sys_busy;
      rd_data[CTRL_EXT] = ext_bit;
    end else if (rd_addr == ADDR_W'(REG_STAT)) begin
      rd_data = stat;
    end else if (rd_addr == ADDR_W'(REG_CFG)) begin
      rd_data[0]   = wake_cfg_o;
      rd_data[2:1] = pll_cfg_o;
    end
  end

  assert_ext_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_done |=> !ext_bit);

  assert_ext_bit_tracks_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bit |-> (rst_out_o && !sys_rst_o));

endmodule

// File: tb/test_swrst_seq.sv
`timescale 1ns/10ps
module test_swrst_seq;

  localparam int POST = 32;
  localparam int EXTN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [4:0] rd_data;
  logic       pll_lock = 1'b0;
  logic       cfg_en = 1'b0;
  logic       wake_pin = 1'b0;
  logic [1:0] boot_pins = '0;
  logic [1:0] pll_cfg_pins = '0;
  logic       sys_rst_o, rst_out_o, wake_cfg_o;
  logic [1:0] pll_cfg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  swrst_seq #(.POST_LOCK(POST), .EXT_LEN(EXTN), .ADDR_W(2)) i_swrst_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pll_lock(pll_lock), .cfg_en(cfg_en),
    .wake_pin(wake_pin), .boot_pins(boot_pins), .pll_cfg_pins(pll_cfg_pins),
    .sys_rst_o(sys_rst_o), .rst_out_o(rst_out_o), .wake_cfg_o(wake_cfg_o),
    .pll_cfg_o(pll_cfg_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [4:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  // status image: [0] full flag, [1] pin flag, [2] wake, [4:3] boot
  logic [4:0] exp_stat = '0;

  task automatic t_reset_state();
    logic [4:0] v;
    check("R1 reset rst_out", {7'b0, rst_out_o}, 8'd0);
    check("R1 reset sys_rst", {7'b0, sys_rst_o}, 8'd0);
    rd(2'd1, v); check("R5 reset status", {3'b0, v}, 8'd0);
    rd(2'd0, v); check("R7 reset control", {3'b0, v}, 8'd0);
  endtask

  task automatic t_pin_pulse();
    logic [4:0] v;
    bus_write(2'd0, 2'b10);
    check("R6 pin asserted", {7'b0, rst_out_o}, 8'd1);
    check("R6 internal low", {7'b0, sys_rst_o}, 8'd0);
    rd(2'd0, v); check("R7 ext bit set", {3'b0, v}, 8'h02);
    repeat (EXTN - 1) tick();
    check("R6 pin still high at end", {7'b0, rst_out_o}, 8'd1);
    tick();
    check("R6 pin released", {7'b0, rst_out_o}, 8'd0);
    rd(2'd0, v); check("R7 ext bit cleared", {3'b0, v}, 8'h00);
    exp_stat[1] = 1'b1;
    rd(2'd1, v); check("R8 flag set, others kept", {3'b0, v}, {3'b0, exp_stat});
  endtask

  task automatic t_pin_busy_ignore();
    logic [4:0] v;
    bus_write(2'd0, 2'b10);
    repeat (4) tick();
    bus_write(2'd0, 2'b10);
    repeat (EXTN - 6) tick();
    check("R10 pin high before original end", {7'b0, rst_out_o}, 8'd1);
    tick();
    check("R10 pulse ends at original time", {7'b0, rst_out_o}, 8'd0);
    rd(2'd0, v); check("R10 control idle", {3'b0, v}, 8'h00);
  endtask

  task automatic t_clear(input logic [1:0] mask);
    logic [4:0] v;
    bus_write(2'd1, mask);
    exp_stat[1:0] = exp_stat[1:0] & ~mask;
    rd(2'd1, v); check("R9 write-one-to-clear", {3'b0, v}, {3'b0, exp_stat});
  endtask

  task automatic t_full(input logic ce, input logic w, input logic [1:0] bt,
                        input logic [1:0] pl, input logic [1:0] exp_pll);
    logic [4:0] v;
    cfg_en = ce; wake_pin = w; pll_cfg_pins = pl; boot_pins = ~bt; pll_lock = 1'b0;
    bus_write(2'd0, 2'b01);
    check("R1 internal asserted", {7'b0, sys_rst_o}, 8'd1);
    check("R1 pin asserted", {7'b0, rst_out_o}, 8'd1);
    rd(2'd2, v); check("R2 applied config", {3'b0, v}, {5'b0, exp_pll, w});
    rd(2'd0, v); check("R7 full busy bit", {3'b0, v}, 8'h01);
    wake_pin = ~w;
    repeat (6) tick();
    check("R3 waits for lock", {7'b0, rst_out_o}, 8'd1);
    pll_lock = 1'b1;
    tick();
    repeat (POST - 1) tick();
    wake_pin = w; boot_pins = bt;
    tick();
    wake_pin = ~w; boot_pins = ~bt;
    repeat (3) tick();
    check("R4 pin held through tail", {7'b0, rst_out_o}, 8'd1);
    rd(2'd1, v); check("R4 status not yet updated", {3'b0, v}, {3'b0, exp_stat});
    tick();
    check("R4 pin released", {7'b0, rst_out_o}, 8'd0);
    check("R4 internal released", {7'b0, sys_rst_o}, 8'd0);
    if (ce) exp_stat[4:3] = bt;
    exp_stat[2] = w;
    exp_stat[1:0] = 2'b01;
    rd(2'd1, v); check("R5 R3 status after full reset", {3'b0, v}, {3'b0, exp_stat});
    rd(2'd2, v); check("R2 applied wake kept", {3'b0, v}, {5'b0, exp_pll, w});
    pll_lock = 1'b0;
  endtask

  task automatic t_priority();
    logic [4:0] v;
    cfg_en = 1'b0; pll_lock = 1'b0;
    bus_write(2'd0, 2'b11);
    check("R11 full reset wins", {7'b0, sys_rst_o}, 8'd1);
    rd(2'd0, v); check("R11 pin request dropped", {3'b0, v}, 8'h01);
    rd(2'd1, v); check("R11 no pin flag", {7'b0, v[1]}, 8'd0);
    bus_write(2'd0, 2'b10);
    rd(2'd1, v); check("R10 pin write during full ignored", {7'b0, v[1]}, 8'd0);
    check("R10 internal still held", {7'b0, sys_rst_o}, 8'd1);
    wake_pin = 1'b0;
    pll_lock = 1'b1;
    repeat (POST + 5) tick();
    check("R4 sequence completed", {7'b0, rst_out_o}, 8'd0);
    exp_stat[2] = 1'b0;
    exp_stat[1:0] = 2'b01;
    pll_lock = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset_state();
    t_pin_pulse();
    t_pin_busy_ignore();
    t_clear(2'b10);
    t_pin_pulse();
    t_full(1'b1, 1'b1, 2'b10, 2'b01, 2'b01);
    t_pin_pulse();
    t_clear(2'b01);
    t_clear(2'b00);
    t_full(1'b0, 1'b0, 2'b01, 2'b10, 2'b01);
    t_clear(2'b11);
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule